// File: doc/BRIEF.md
# Self-Checking Single-Chain Carry-Select Adder

This block adds two unsigned operands and a carry-in. It uses one ripple chain of self-checking full-adder cells, and that chain always runs with its initial carry tied to zero. The result for a carry-in of one is not computed by a second adder. It is derived from the zero-carry sum bits by a small prefix network. A bit flips when every zero-carry sum bit below it is one. The carry-out for a carry-in of one is the zero-carry carry XOR the AND of all zero-carry sum bits.

The real carry-in then selects one of the two candidate words. Each cell also reports a local error flag. The flag compares the cell's sum against its carry-out, using a tester that notes whether the cell's three inputs are all alike. A sum and carry that agree are legal only when all three inputs are alike. A sum and carry that differ are legal only when the inputs are not all alike. Because each flag depends only on its own cell, a bad carry passed along the chain does not raise flags in the cells above it. The error vector therefore points at the faulty cell.

The block is purely combinational. It is meant to sit inside a datapath that needs fault localisation at full-adder granularity.

Top module: `sc_csel_adder`

## Requirements
- R1: For every operand pair and carry-in, {carry_out, sum_out} equals op_a + op_b + carry_in as an unsigned WIDTH+1 bit value.
- R2: With carry_in = 0 the outputs are the zero-carry chain result, op_a + op_b, including its carry-out.
- R3: In fault-free operation every bit of cell_err (bit i belongs to the cell at sum bit i, 1 = fault) is 0 for every input.
- R4: Bit 0 of sum_out with carry_in = 1 is the complement of bit 0 of sum_out with carry_in = 0, for the same operands.
- R5: For bit j above 0, sum_out[j] with carry_in = 1 equals sum_out[j] with carry_in = 0 inverted exactly when all bits below j of the carry_in = 0 sum are 1; otherwise the two are equal.
- R6: carry_out with carry_in = 1 equals carry_out with carry_in = 0 XOR the AND of all carry_in = 0 sum bits. The two terms are never both 1.
- R7: At the range limits the outputs are as follows. If op_a + op_b is all ones and carry_in = 1, sum_out is 0 and carry_out is 1. If both operands are all ones, the result has carry_out 1, and sum_out is all ones with bit 0 cleared when carry_in = 0, or all ones when carry_in = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0; selects the candidate result |
| sum_out | output | WIDTH | Selected sum |
| carry_out | output | 1 | Selected carry-out |
| cell_err | output | WIDTH | Per-cell self-check flag, bit i for cell i |

## Verification
Small operands with every combination of the low four bits and both carry-in values cover each cell's input triples. This separates the cases where sum and carry must agree from those where they must differ. Random full-width operands then exercise long and short carry runs together.

Directed pairs apply the same operands with carry-in 0 and then 1. These isolate the derived result: the bit 0 complement, the prefix flip rule for zero-carry sums with a chosen number of trailing ones, and the carry XOR term. Operands whose zero-carry sum is all ones, and operands that are both all ones, separate a wrap to zero from a full overflow.

// File: rtl/scsa_pkg.sv
package scsa_pkg;
  parameter int unsigned SCSA_DEF_WIDTH = 16;

  // Raw outputs of one self-checking cell; uneq is high when the three
  // inputs are not all equal.
  typedef struct packed {
    logic sum;
    logic cout;
    logic uneq;
  } cell_raw_t;
endpackage

// File: rtl/scsa_cell.sv
module scsa_cell
  import scsa_pkg::*;
(
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic sum_o,
  output logic cout_o,
  output logic err_o
);
  cell_raw_t raw;

  // Sum and carry are built from the inputs with no shared term.
  always_comb begin
    raw.sum  = x_i ^ y_i ^ c_i;
    raw.cout = (x_i & y_i) | (c_i & (x_i | y_i));
    raw.uneq = ~((x_i & y_i & c_i) | (~x_i & ~y_i & ~c_i));
  end

  // First comparator: do sum and carry agree?  Second: is that agreement
  // legal for the input pattern reported by the tester?
  logic agree;
  always_comb begin
    agree  = ~(raw.sum ^ raw.cout);
    err_o  = ~(agree ^ raw.uneq);
    sum_o  = raw.sum;
    cout_o = raw.cout;
  end

  // R3: a fault-free cell never raises its flag
  always_comb begin
    a_r3_cell_clean: assert (err_o == 1'b0)
      else $error("cell flag raised: x=%b y=%b c=%b", x_i, y_i, c_i);
  end
endmodule

// File: rtl/scsa_chain.sv
module scsa_chain #(
  parameter int unsigned WIDTH = scsa_pkg::SCSA_DEF_WIDTH
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] sum0,
  output logic             cout0,
  output logic [WIDTH-1:0] err
);
  logic [WIDTH:0] rip;

  assign rip[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    scsa_cell u_cell (
      .x_i    (op_a[i]),
      .y_i    (op_b[i]),
      .c_i    (rip[i]),
      .sum_o  (sum0[i]),
      .cout_o (rip[i+1]),
      .err_o  (err[i])
    );
  end

  assign cout0 = rip[WIDTH];

  // R2: the zero-carry chain result is the plain operand sum
  always_comb begin
    a_r2_chain_sum: assert ({cout0, sum0} == ({1'b0, op_a} + {1'b0, op_b}))
      else $error("chain sum wrong");
  end
endmodule

// File: rtl/scsa_derive.sv
module scsa_derive #(
  parameter int unsigned WIDTH = scsa_pkg::SCSA_DEF_WIDTH
) (
  input  logic [WIDTH-1:0] sum0,
  input  logic             cout0,
  output logic [WIDTH-1:0] sum1,
  output logic             cout1
);
  // run[j] is high when all zero-carry sum bits below j are one.
  logic [WIDTH:0] run;

  assign run[0] = 1'b1;

  for (genvar j = 0; j < WIDTH; j++) begin : g_pfx
    assign run[j+1] = run[j] & sum0[j];
    assign sum1[j]  = sum0[j] ^ run[j];
  end

  assign cout1 = cout0 ^ run[WIDTH];

  // R6: the two carry terms are mutually exclusive, so XOR equals OR
  always_comb begin
    a_r6_terms_exclusive: assert (!(cout0 && run[WIDTH]))
      else $error("carry terms overlap");
  end
endmodule

// File: rtl/sc_csel_adder.sv
module sc_csel_adder #(
  parameter int unsigned WIDTH = scsa_pkg::SCSA_DEF_WIDTH
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out,
  output logic [WIDTH-1:0] cell_err
);
  localparam int unsigned RW = WIDTH + 1;

  logic [WIDTH-1:0] s0;
  logic [WIDTH-1:0] s1;
  logic             c0;
  logic             c1;

  scsa_chain #(.WIDTH(WIDTH)) u_chain (
    .op_a  (op_a),
    .op_b  (op_b),
    .sum0  (s0),
    .cout0 (c0),
    .err   (cell_err)
  );

  scsa_derive #(.WIDTH(WIDTH)) u_derive (
    .sum0  (s0),
    .cout0 (c0),
    .sum1  (s1),
    .cout1 (c1)
  );

  always_comb begin
    if (carry_in) begin
      sum_out   = s1;
      carry_out = c1;
    end else begin
      sum_out   = s0;
      carry_out = c0;
    end
  end

  // R4/R5: the derived word is the chain word plus one
  always_comb begin
    a_r5_derived_plus_one: assert ({c1, s1} == ({c0, s0} + RW'(1)))
      else $error("derived result is not chain result plus one");
  end

  // R1: the selected output is the full three-input sum
  always_comb begin
    a_r1_total: assert ({carry_out, sum_out} ==
                        ({1'b0, op_a} + {1'b0, op_b} + RW'(carry_in)))
      else $error("selected result wrong");
  end
endmodule

// File: tb/sc_csel_adder_tb.sv
module sc_csel_adder_tb;
  localparam int unsigned W = 16;

  logic         clk;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic         ci;
  logic [W-1:0] s;
  logic         co;
  logic [W-1:0] e;

  int n_chk;
  int n_bad;

  sc_csel_adder #(.WIDTH(W)) u_dut (
    .op_a      (a),
    .op_b      (b),
    .carry_in  (ci),
    .sum_out   (s),
    .carry_out (co),
    .cell_err  (e)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (a=%h b=%h ci=%b)", req, act, exp, a, b, ci);
    end
  endtask

  // drive after a rising edge, sample at the following falling edge
  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
    @(posedge clk);
    #1;
    a = va; b = vb; ci = vc;
    @(negedge clk);
  endtask

  task automatic apply_and_sum(input logic [W-1:0] va, input logic [W-1:0] vb,
                               input logic vc, input string req);
    logic [W:0] ref_v;
    apply(va, vb, vc);
    ref_v = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
    chk(req, {co, s}, ref_v);
    chk("R3", {1'b0, e}, '0);
  endtask

  task automatic t_zero;
    apply_and_sum('0, '0, 1'b0, "R2 zero");
    chk("R1 zero outputs", {co, s}, '0);
  endtask

  task automatic t_exhaustive_low4;
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        for (int c = 0; c < 2; c++)
          apply_and_sum(W'(i), W'(j), c[0], c == 0 ? "R2 exh4" : "R1 exh4");
  endtask

  task automatic t_random;
    for (int k = 0; k < 400; k++)
      apply_and_sum(W'($urandom), W'($urandom), 1'($urandom), "R1 random");
  endtask

  // same operands with carry-in 0 then 1; check bit 0, flip rule, carry rule
  task automatic t_pair(input logic [W-1:0] va, input logic [W-1:0] vb);
    logic [W-1:0] z_s;
    logic         z_c;
    logic         allone;
    apply(va, vb, 1'b0);
    z_s = s; z_c = co;
    apply(va, vb, 1'b1);
    chk("R4 bit0 complement", {{W{1'b0}}, s[0]}, {{W{1'b0}}, ~z_s[0]});
    allone = z_s[0];
    for (int j = 1; j < W; j++) begin
      chk("R5 flip rule", {{W{1'b0}}, s[j]}, {{W{1'b0}}, z_s[j] ^ allone});
      allone = allone & z_s[j];
    end
    chk("R6 carry xor", {{W{1'b0}}, co}, {{W{1'b0}}, z_c ^ allone});
    chk("R6 exclusive", {{W{1'b0}}, z_c & allone}, '0);
    chk("R3 pair", {1'b0, e}, '0);
  endtask

  task automatic t_prefix_patterns;
    // zero-carry sum with k trailing ones and a zero above them
    for (int k = 0; k < W; k++) begin
      logic [W-1:0] tgt;
      tgt = (W'(1) << k) - W'(1);
      tgt = tgt | (W'(16'hA5A4) << (k + 1));
      t_pair(tgt, '0);
      t_pair(tgt >> 1, tgt - (tgt >> 1));
    end
    t_pair(16'h8001, 16'h8000);
    t_pair(16'h1234, 16'h4321);
  endtask

  task automatic t_limits;
    apply_and_sum('1, '0, 1'b1, "R7 wrap");
    chk("R7 wrap exact", {co, s}, {1'b1, {W{1'b0}}});
    apply_and_sum(16'hF0F0, 16'h0F0F, 1'b1, "R7 wrap split");
    chk("R7 wrap split exact", {co, s}, {1'b1, {W{1'b0}}});
    apply_and_sum('1, '1, 1'b0, "R7 max ci0");
    chk("R7 max ci0 exact", {co, s}, {1'b1, {(W-1){1'b1}}, 1'b0});
    apply_and_sum('1, '1, 1'b1, "R7 max ci1");
    chk("R7 max ci1 exact", {co, s}, {1'b1, {W{1'b1}}});
    t_pair('1, '0);
    t_pair('1, '1);
  endtask

  logic done;

  initial begin
    done = 1'b0;
    n_chk = 0; n_bad = 0;
    a = '0; b = '0; ci = 1'b0;
    t_zero;
    t_exhaustive_low4;
    t_random;
    t_prefix_patterns;
    t_limits;
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 150000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule